// File: doc/BRIEF.md
# MDIO Management Shift Engine

This block runs station-management frames of the kind used on a clause 22 PHY management bus. Software places a whole 32-bit frame image in one maintenance register. Writing that register starts the transfer. The register is the shift register itself. Its most significant bit goes out on the management data line. Its least significant bit is refilled with the level sampled on the line during each management clock cycle.

The management clock is made by dividing the system clock. A 3-bit select input picks the ratio, and the ratio is latched when each operation starts. After 32 management clock cycles, every bit written by software has rotated back to its own position. On a read frame, the trailing 18 bits (turnaround and data) now hold what the PHY drove. Completion sets a done flag and gives a one-cycle interrupt pulse.

Top module: `mdio_shift_engine`

## Requirements
- R1: A `wr_en` pulse while idle loads `wr_data` into the register and raises `busy` at the next clock edge. The same edge clears `done`.
- R2: `div_sel` picks the system clocks per management clock period: 0→16, 1→32, 2→64, 3→96, 4→128, 5→192, and 6 or 7→192. `mdc` stays high for half of each period, and `busy` stays high for exactly 32 periods.
- R3: Line bits leave most significant bit first, one per `mdc` period, and change only when `mdc` falls. The input is sampled on the clock edge where `mdc` rises.
- R4: A read frame has bits [29:28] = 2'b10. For a read frame, `mdio_oe` is high for the first 14 bit periods only. For any other opcode, it is high for all 32 periods. `mdio_oe` is low whenever the block is idle.
- R5: After completion, `rd_data` equals the written value. The exception is a read frame, where bits [17:0] hold the 18 sampled bits, first sample in bit 17. While the block is driving the line, it samples its own output bit.
- R6: Partway through an operation, after k falling edges of `mdc`, `rd_data` shows the register rotated left by k places, with sampled bits entering at bit 0.
- R7: On completion, `done` is set, and `irq` is high for exactly one clock cycle. `done` then holds until the next operation starts.
- R8: A `wr_en` pulse while `busy` is high changes neither the register nor the running operation, and `done` stays low until the operation ends.
- R9: After reset, the block is idle: `rd_data` is 0, and `busy`, `done`, `irq`, `mdc` and `mdio_oe` are all low.
- R10: While idle, `mdc` is held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Maintenance register write strobe |
| wr_data | input | 32 | Frame image to send |
| div_sel | input | 3 | Management clock divider select |
| mdio_i | input | 1 | Management data line input |
| rd_data | output | 32 | Current register contents |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Operation completed (status bit) |
| irq | output | 1 | One-cycle completion interrupt |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data line output value |
| mdio_oe | output | 1 | Management data line output enable |

## Verification
The assertions rely on `wr_en` being a synchronous strobe. They also rely on `mdio_i` mattering only while `mdio_oe` is low. They place no limits on when writes arrive, so writes while busy are legal stimulus. The bench holds `div_sel` steady through each operation, although the design latches it anyway. The bench's PHY model drives the line only in the bit periods where the engine has released it. It changes its level only on falling edges of `mdc`, so every sample sees a stable level.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int RATIO_W = 8;

  // Opcode field position and the code that marks a read frame.
  localparam int OP_HI = 29;
  localparam int OP_LO = 28;
  localparam logic [1:0] OP_READ = 2'b10;

  // Divider select to system clocks per management clock period.
  function automatic logic [RATIO_W-1:0] div_ratio(input logic [2:0] sel);
    case (sel)
      3'd0:    div_ratio = 8'd16;
      3'd1:    div_ratio = 8'd32;
      3'd2:    div_ratio = 8'd64;
      3'd3:    div_ratio = 8'd96;
      3'd4:    div_ratio = 8'd128;
      default: div_ratio = 8'd192;
    endcase
  endfunction
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div
  import mdio_pkg::*;
#(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             mdc,
  output logic             rise_stb,
  output logic             fall_stb
);
  logic [RATIO_W-1:0] ratio_q;
  logic [RATIO_W-1:0] cnt;
  logic [RATIO_W-1:0] half;

  assign half     = ratio_q >> 1;
  assign rise_stb = run && (cnt == half - 1'b1);
  assign fall_stb = run && (cnt == ratio_q - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      ratio_q <= div_ratio(3'd0);
      cnt     <= '0;
      mdc     <= 1'b0;
    end else if (start) begin
      ratio_q <= div_ratio(3'(sel));
      cnt     <= '0;
      mdc     <= 1'b0;
    end else if (run) begin
      cnt <= fall_stb ? '0 : cnt + 1'b1;
      if (rise_stb)
        mdc <= 1'b1;
      else if (fall_stb)
        mdc <= 1'b0;
    end else begin
      mdc <= 1'b0;
    end
  end
endmodule

// File: rtl/mdio_shift_reg.sv
module mdio_shift_reg #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [DW-1:0] load_val,
  input  logic          rise_stb,
  input  logic          fall_stb,
  input  logic          drive,
  input  logic          line_in,
  output logic [DW-1:0] sr
);
  logic cap;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr  <= '0;
      cap <= 1'b0;
    end else if (start) begin
      sr  <= load_val;
      cap <= 1'b0;
    end else begin
      if (rise_stb)
        cap <= drive ? sr[DW-1] : line_in;
      if (fall_stb)
        sr <= {sr[DW-2:0], cap};
    end
  end
endmodule

// File: rtl/mdio_frame_ctl.sv
module mdio_frame_ctl #(
  parameter int DW       = 32,
  parameter int RD_DRIVE = 14,
  localparam int IDX_W   = $clog2(DW)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             rd_frame,
  input  logic             fall_stb,
  output logic             busy,
  output logic             done,
  output logic             irq,
  output logic             oe,
  output logic             rd_op,
  output logic [IDX_W-1:0] bit_idx
);
  logic last;
  int   nxt;

  assign last = fall_stb && (bit_idx == IDX_W'(DW - 1));
  assign nxt  = int'(bit_idx) + 1;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      irq     <= 1'b0;
      oe      <= 1'b0;
      rd_op   <= 1'b0;
      bit_idx <= '0;
    end else begin
      irq <= 1'b0;
      if (start) begin
        busy    <= 1'b1;
        done    <= 1'b0;
        oe      <= 1'b1;
        rd_op   <= rd_frame;
        bit_idx <= '0;
      end else if (fall_stb) begin
        if (last) begin
          busy    <= 1'b0;
          done    <= 1'b1;
          irq     <= 1'b1;
          oe      <= 1'b0;
          bit_idx <= '0;
        end else begin
          bit_idx <= bit_idx + 1'b1;
          oe      <= !rd_op || (nxt < RD_DRIVE);
        end
      end
    end
  end
endmodule

// File: rtl/mdio_shift_engine.sv
module mdio_shift_engine
  import mdio_pkg::*;
#(
  parameter int DW       = 32,
  parameter int SEL_W    = 3,
  parameter int RD_DRIVE = 14,
  localparam int IDX_W   = $clog2(DW)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [DW-1:0]    wr_data,
  input  logic [SEL_W-1:0] div_sel,
  input  logic             mdio_i,
  output logic [DW-1:0]    rd_data,
  output logic             busy,
  output logic             done,
  output logic             irq,
  output logic             mdc,
  output logic             mdio_o,
  output logic             mdio_oe
);
  logic             start;
  logic             rise_stb;
  logic             fall_stb;
  logic             rd_op;
  logic [IDX_W-1:0] bit_idx;
  logic [DW-1:0]    sr;

  assign start = wr_en && !busy;

  mdio_clk_div #(.SEL_W(SEL_W)) u_div (
    .clk(clk), .rst(rst), .start(start), .run(busy), .sel(div_sel),
    .mdc(mdc), .rise_stb(rise_stb), .fall_stb(fall_stb)
  );

  mdio_frame_ctl #(.DW(DW), .RD_DRIVE(RD_DRIVE)) u_ctl (
    .clk(clk), .rst(rst), .start(start),
    .rd_frame(wr_data[OP_HI:OP_LO] == OP_READ),
    .fall_stb(fall_stb), .busy(busy), .done(done), .irq(irq),
    .oe(mdio_oe), .rd_op(rd_op), .bit_idx(bit_idx)
  );

  mdio_shift_reg #(.DW(DW)) u_sr (
    .clk(clk), .rst(rst), .start(start), .load_val(wr_data),
    .rise_stb(rise_stb), .fall_stb(fall_stb), .drive(mdio_oe),
    .line_in(mdio_i), .sr(sr)
  );

  assign rd_data = sr;
  assign mdio_o  = sr[DW-1];
endmodule

// File: rtl/mdio_shift_chk.sv
module mdio_shift_chk #(
  parameter int DW       = 32,
  parameter int RD_DRIVE = 14,
  localparam int IDX_W   = $clog2(DW)
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [DW-1:0]    wr_data,
  input logic [DW-1:0]    rd_data,
  input logic             busy,
  input logic             done,
  input logic             irq,
  input logic             mdc,
  input logic             mdio_oe,
  input logic             rd_op,
  input logic [IDX_W-1:0] bit_idx
);
  assert_start_load_R1: assert property (@(posedge clk) disable iff (rst)
    wr_en && !busy |=> busy && !done && rd_data == $past(wr_data));

  assert_read_release_R4: assert property (@(posedge clk) disable iff (rst)
    busy && rd_op && int'(bit_idx) >= RD_DRIVE |-> !mdio_oe);

  assert_drive_head_R4: assert property (@(posedge clk) disable iff (rst)
    busy && int'(bit_idx) < RD_DRIVE |-> mdio_oe);

  assert_irq_single_R7: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);

  assert_irq_with_done_R7: assert property (@(posedge clk) disable iff (rst)
    irq |-> done && !busy);

  assert_hold_between_falls_R8: assert property (@(posedge clk) disable iff (rst)
    busy && $past(busy) && !$fell(mdc) |-> $stable(rd_data));

  assert_done_low_busy_R8: assert property (@(posedge clk) disable iff (rst)
    busy |-> !done);

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdc && !mdio_oe);
endmodule

bind mdio_shift_engine mdio_shift_chk #(.DW(DW), .RD_DRIVE(RD_DRIVE)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
  .busy(busy), .done(done), .irq(irq), .mdc(mdc), .mdio_oe(mdio_oe),
  .rd_op(rd_op), .bit_idx(bit_idx)
);

// File: tb/tb_mdio_shift_engine.sv
module tb_mdio_shift_engine;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [2:0]  div_sel = '0;
  logic        mdio_i;
  logic [31:0] rd_data;
  logic        busy, done, irq, mdc, mdio_o, mdio_oe;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  mdio_shift_engine dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .div_sel(div_sel),
    .mdio_i(mdio_i), .rd_data(rd_data), .busy(busy), .done(done), .irq(irq),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  // PHY model: drives its pattern in bit periods 14..31, changes on mdc fall.
  int          bidx = 0;
  logic [17:0] phy_pat = '0;
  logic [31:0] tx_bits = '0;
  int          oe_cnt = 0;
  logic        phy_bit;

  assign phy_bit = (bidx >= 14 && bidx < 32) ? phy_pat[31 - bidx] : 1'b1;
  assign mdio_i  = mdio_oe ? mdio_o : phy_bit;

  always @(negedge mdc) bidx = bidx + 1;
  always @(posedge mdc) begin
    tx_bits = {tx_bits[30:0], mdio_o};
    if (mdio_oe) oe_cnt = oe_cnt + 1;
  end

  typedef struct packed {
    logic [2:0]  sel;
    logic [31:0] wr;
    logic [17:0] phy;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VEC [NV] = '{
    '{3'd0, 32'h5123ABCD, 18'h00000, 32'h5123ABCD},
    '{3'd0, 32'h6A5E0000, 18'h2BEEF, 32'h6A5EBEEF},
    '{3'd1, 32'h6FFFFFFF, 18'h00000, 32'h6FFC0000},
    '{3'd2, 32'h5AAA5555, 18'h3FFFF, 32'h5AAA5555},
    '{3'd7, 32'h60000000, 18'h3FFFF, 32'h6003FFFF},
    '{3'd3, 32'h0F0F1234, 18'h15555, 32'h0F0F1234},
    '{3'd5, 32'h5FFFFFFF, 18'h00000, 32'h5FFFFFFF}
  };

  function automatic int ratio_of(input logic [2:0] s);
    case (s)
      3'd0: return 16;
      3'd1: return 32;
      3'd2: return 64;
      3'd3: return 96;
      3'd4: return 128;
      default: return 192;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic start_op(input logic [2:0] s, input logic [31:0] d,
                          input logic [17:0] p);
    @(negedge clk);
    phy_pat = p; bidx = 0; tx_bits = '0; oe_cnt = 0;
    div_sel = s; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    check(busy == 1'b1 && done == 1'b0, "R1 busy/done", {busy, done}, 2'b10);
    check(rd_data == d, "R1 load", rd_data, d);
  endtask

  task automatic finish_op(input logic [2:0] s, input logic [31:0] d,
                           input logic [31:0] exp, input int busy_before);
    int bcnt = busy_before;
    int hcnt = 0;
    int icnt = 0;
    bit rd = (d[29:28] == 2'b10);
    while (busy) begin
      if (mdc) hcnt++;
      @(negedge clk);
      if (busy) bcnt++;
      if (irq) icnt++;
    end
    @(negedge clk);
    if (irq) icnt++;
    check(bcnt == 32 * ratio_of(s), "R2 op length", bcnt, 32 * ratio_of(s));
    check(hcnt == 16 * ratio_of(s), "R2 mdc high time", hcnt, 16 * ratio_of(s));
    check(tx_bits == d, "R3 serial order", tx_bits, d);
    check(oe_cnt == (rd ? 14 : 32), "R4 drive span", oe_cnt, rd ? 14 : 32);
    check(rd_data == exp, "R5 final contents", rd_data, exp);
    check(done == 1'b1 && icnt == 1, "R7 done/irq pulse", {done, 8'(icnt)}, 9'h101);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    check(rd_data == 0 && {busy, done, irq, mdc, mdio_oe} == 5'b0, "R9 reset",
          {rd_data[26:0], busy, done, irq, mdc, mdio_oe}, 0);

    // Vector walk
    for (int i = 0; i < NV; i++) begin
      start_op(VEC[i].sel, VEC[i].wr, VEC[i].phy);
      finish_op(VEC[i].sel, VEC[i].wr, VEC[i].exp, 1);
    end

    // R7 done holds, R10 idle quiet
    repeat (5) @(negedge clk);
    check(done == 1'b1, "R7 done holds", done, 1);
    check(mdc == 1'b0 && mdio_oe == 1'b0, "R10 idle mdc/oe", {mdc, mdio_oe}, 0);

    // R8 write during busy ignored; R6 partial rotation
    start_op(3'd0, 32'h5123ABCD, 18'h0);
    repeat (3) @(negedge clk);
    wr_data = 32'h6FFF0000; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    check(rd_data == 32'h5123ABCD && done == 1'b0, "R8 write ignored",
          rd_data, 32'h5123ABCD);
    wait (bidx == 4);
    @(negedge clk);
    check(rd_data == 32'h123ABCD5, "R6 partial rotate", rd_data, 32'h123ABCD5);
    begin
      int waited = 0;
      while (busy) begin @(negedge clk); waited++; end
    end
    @(negedge clk);
    check(rd_data == 32'h5123ABCD, "R8 result intact", rd_data, 32'h5123ABCD);
    check(tx_bits == 32'h5123ABCD, "R3 serial after ignore", tx_bits, 32'h5123ABCD);

    // R1 done clears on new start
    start_op(3'd0, 32'h5000000F, 18'h0);
    finish_op(3'd0, 32'h5000000F, 32'h5000000F, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule